// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block sits beside a floating-point datapath. For every completed operation the datapath presents six exception flags: invalid, divide-by-zero, overflow, underflow, inexact and integer overflow. It also presents a mask of flags to ignore, the number of the destination register, a software-completion select and a mask of enabled flags. The unit folds the flags into a sticky status register and decides whether the operation traps. A trap is a registered one-cycle pulse. It carries a summary code and a one-hot mask that marks the destination register.

There are two trap policies. In plain mode every raised flag becomes sticky, and the operation traps when any flag survives the ignore mask. In software-completion mode only the flags that are not ignored become sticky. The summary then holds only the enabled flags and carries a completion bit. The parameter `USER_POLICY` selects how a software-completion operation with no enabled flag is handled. With `USER_POLICY`=1 it does not trap. With `USER_POLICY`=0 it traps whenever any flag survives the ignore mask. Software can overwrite the status register through a write port.

The trap control is a two-state machine.
- `ST_IDLE`: no trap is being signalled.
- `ST_TRAP`: the trap outputs are driven for this cycle.
- Transition `fire`: a valid operation that must trap moves the machine to `ST_TRAP`, from either state.
- Transition `drain`: in any other cycle the machine returns to `ST_IDLE`.

Top module: `fpx_trap_unit`

## Requirements
- R1: Synchronous reset clears `status_q`, `trap_pulse`, `trap_summary` and `trap_regmask` to zero.
- R2: Flag bit positions are [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact, [5] integer overflow. `status_q` uses the same positions. In plain mode (`swc_mode`=0), every flag of a valid operation is ORed into `status_q`, including ignored flags, and is visible one cycle after `op_valid`.
- R3: In plain mode the operation traps exactly when `op_flags & ~ignore_mask` is nonzero. `trap_summary` bit k+1 then equals that masked flag k, and bit 0 is 0. `enable_mask` has no effect in plain mode.
- R4: `trap_pulse` is high for exactly one cycle, in the cycle after a trapping valid operation. While `trap_pulse` is low, `trap_summary` and `trap_regmask` are zero. While `op_valid` is low, the flags have no effect on `status_q` or on the trap outputs.
- R5: In software-completion mode (`swc_mode`=1), only `op_flags & ~ignore_mask` is ORed into `status_q`.
- R6: When a software-completion operation traps, `trap_summary` bit 0 is 1. Bit k+1 equals flag k of `op_flags & ~ignore_mask & enable_mask`.
- R7: A software-completion operation traps as follows. With `USER_POLICY`=1 it traps only if `op_flags & ~ignore_mask & enable_mask` is nonzero. With `USER_POLICY`=0 it traps if `op_flags & ~ignore_mask` is nonzero.
- R8: On a trap, `trap_regmask` has exactly one bit set, at index `dest_reg`.
- R9: A software write replaces `status_q` with `sw_wr_data`. If a valid operation arrives in the same cycle, its sticky flags are ORed on top of the written value.
- R10: Status bits stay set across later operations that raise no flags, until software writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies the operation inputs |
| op_flags | input | 6 | Exception flags of the operation |
| ignore_mask | input | 6 | Flags that must not trap |
| enable_mask | input | 6 | Enabled flags for software-completion mode |
| swc_mode | input | 1 | 1 selects the software-completion policy |
| dest_reg | input | $clog2(NUM_REGS) | Destination register number |
| sw_wr_en | input | 1 | Status register write strobe |
| sw_wr_data | input | 6 | Status register write value |
| status_q | output | 6 | Sticky status register |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_summary | output | 7 | Trap summary, bit 0 is the completion indicator |
| trap_regmask | output | NUM_REGS | One-hot destination register mask |

## Verification
The bench drives the same operations into one instance of each policy. It covers these corner cases:
- A plain operation whose raised flags are all ignored must still become sticky but must not trap. A design that applies the ignore mask before the OR would lose those status bits.
- A software-completion operation whose ignored flag is raised must leave the status untouched.
- An operation whose only surviving flag is disabled must split the two policies. The system-style instance must trap with only the completion bit set, while the user-style instance stays quiet.
- Other checks cover a write colliding with an operation, which must yield the OR of both; flags presented without `op_valid`; and the edge indices 0 and 31 of the register mask.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_W  = 6;
    localparam int SUM_W   = FLAG_W + 1;
    localparam int SUM_SWC = 0;

    typedef logic [FLAG_W-1:0] flags_t;
    typedef logic [SUM_W-1:0]  summary_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } trap_state_e;
endpackage

// File: rtl/fpx_filter.sv
module fpx_filter
    import fpx_pkg::*;
#(
    parameter bit USER_POLICY = 1'b1
) (
    input  flags_t   flags,
    input  flags_t   ignore_mask,
    input  flags_t   enable_mask,
    input  logic     swc_mode,
    output flags_t   sticky_bits,
    output logic     raise,
    output summary_t summary
);
    flags_t kept;
    flags_t armed;
    flags_t report;

    assign kept  = flags & ~ignore_mask;
    assign armed = kept & enable_mask;

    always_comb begin
        if (swc_mode) begin
            sticky_bits = kept;
            report      = armed;
            raise       = USER_POLICY ? (|armed) : (|kept);
        end else begin
            sticky_bits = flags;
            report      = kept;
            raise       = |kept;
        end
    end

    assign summary[SUM_SWC] = swc_mode;

    // flag k lands on summary bit k+1
    for (genvar k = 0; k < FLAG_W; k++) begin : g_remap
        assign summary[k+1] = report[k];
    end
endmodule

// File: rtl/fpx_status.sv
module fpx_status
    import fpx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_en,
    input  flags_t upd_bits,
    input  logic   wr_en,
    input  flags_t wr_data,
    output flags_t status_q
);
    flags_t or_in;

    assign or_in = upd_en ? upd_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (wr_en) begin
            status_q <= wr_data | or_in;
        end else begin
            status_q <= status_q | or_in;
        end
    end

    // R10: without a write, no status bit ever clears
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> ((status_q & $past(status_q)) == $past(status_q)));

    // R9: a write result always contains the written value
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> ((status_q & $past(wr_data)) == $past(wr_data)));
endmodule

// File: rtl/fpx_trap_fsm.sv
module fpx_trap_fsm
    import fpx_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  summary_t             sum_in,
    input  logic [REG_IDX_W-1:0] dest,
    output logic                 trap_pulse,
    output summary_t             trap_summary,
    output logic [NUM_REGS-1:0]  trap_regmask
);
    trap_state_e state_q;
    trap_state_e state_d;
    logic [NUM_REGS-1:0] onehot_d;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_decode
        assign onehot_d[i] = (dest == REG_IDX_W'(i));
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = fire ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_d = fire ? ST_TRAP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !fire) begin
            trap_summary <= '0;
            trap_regmask <= '0;
        end else begin
            trap_summary <= sum_in;
            trap_regmask <= onehot_d;
        end
    end

    assign trap_pulse = (state_q == ST_TRAP);

    // R8: exactly one register flagged on a trap
    p_regmask_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> ($countones(trap_regmask) == 1));

    // R4: trap payload stays quiet between traps
    p_quiet_payload_r4: assert property (@(posedge clk) disable iff (rst)
        !trap_pulse |-> (trap_summary == '0 && trap_regmask == '0));
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter bit USER_POLICY = 1'b1,
    localparam int REG_IDX_W  = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [FLAG_W-1:0]    op_flags,
    input  logic [FLAG_W-1:0]    ignore_mask,
    input  logic [FLAG_W-1:0]    enable_mask,
    input  logic                 swc_mode,
    input  logic [REG_IDX_W-1:0] dest_reg,
    input  logic                 sw_wr_en,
    input  logic [FLAG_W-1:0]    sw_wr_data,
    output logic [FLAG_W-1:0]    status_q,
    output logic                 trap_pulse,
    output logic [SUM_W-1:0]     trap_summary,
    output logic [NUM_REGS-1:0]  trap_regmask
);
    flags_t   sticky_bits;
    logic     raise;
    summary_t summary;

    fpx_filter #(.USER_POLICY(USER_POLICY)) u_filter (
        .flags       (op_flags),
        .ignore_mask (ignore_mask),
        .enable_mask (enable_mask),
        .swc_mode    (swc_mode),
        .sticky_bits (sticky_bits),
        .raise       (raise),
        .summary     (summary)
    );

    fpx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (op_valid),
        .upd_bits (sticky_bits),
        .wr_en    (sw_wr_en),
        .wr_data  (sw_wr_data),
        .status_q (status_q)
    );

    fpx_trap_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fire         (op_valid && raise),
        .sum_in       (summary),
        .dest         (dest_reg),
        .trap_pulse   (trap_pulse),
        .trap_summary (trap_summary),
        .trap_regmask (trap_regmask)
    );

    // R4: a trap always follows a valid operation
    p_pulse_after_valid_r4: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> $past(op_valid));

    // R6: completion bit mirrors the mode of the trapping operation
    p_swc_bit_r6: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> (trap_summary[SUM_SWC] == $past(swc_mode)));

    // R7: user policy never traps on completion without an enabled flag
    p_user_needs_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        (USER_POLICY && trap_pulse && trap_summary[SUM_SWC]) |-> (|trap_summary[SUM_W-1:1]));
endmodule

// File: tb/fpx_trap_unit_bench.sv
module fpx_trap_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [5:0] op_flags = '0, ignore_mask = '0, enable_mask = '0, sw_wr_data = '0;
    logic swc_mode = 1'b0, sw_wr_en = 1'b0;
    logic [4:0] dest_reg = '0;
    logic [5:0] stat_u, stat_s;
    logic pulse_u, pulse_s;
    logic [6:0] sum_u, sum_s;
    logic [31:0] mask_u, mask_s;
    logic [5:0] exp_stat = '0;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fpx_trap_unit #(.NUM_REGS(32), .USER_POLICY(1'b1)) u_fpx_trap_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
        .ignore_mask(ignore_mask), .enable_mask(enable_mask), .swc_mode(swc_mode),
        .dest_reg(dest_reg), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .status_q(stat_u), .trap_pulse(pulse_u), .trap_summary(sum_u), .trap_regmask(mask_u));

    fpx_trap_unit #(.NUM_REGS(32), .USER_POLICY(1'b0)) u_fpx_trap_unit_sys (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
        .ignore_mask(ignore_mask), .enable_mask(enable_mask), .swc_mode(swc_mode),
        .dest_reg(dest_reg), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .status_q(stat_s), .trap_pulse(pulse_s), .trap_summary(sum_s), .trap_regmask(mask_s));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one operation, checked on both policies
    task automatic run_op(input string req, input logic [5:0] f, input logic [5:0] ign,
                          input logic [5:0] en, input logic [4:0] dst, input logic swc,
                          input logic wr, input logic [5:0] wdat);
        logic [5:0] kept, armed, stick;
        logic tu, ts;
        logic [6:0] su, ss;
        kept  = f & ~ign;
        armed = kept & en;
        if (swc) begin
            stick = kept; tu = |armed; ts = |kept;
            su = {armed, 1'b1}; ss = {armed, 1'b1};
        end else begin
            stick = f; tu = |kept; ts = |kept;
            su = {kept, 1'b0}; ss = {kept, 1'b0};
        end
        exp_stat = wr ? (wdat | stick) : (exp_stat | stick);
        @(negedge clk);
        op_valid = 1'b1; op_flags = f; ignore_mask = ign; enable_mask = en;
        dest_reg = dst; swc_mode = swc; sw_wr_en = wr; sw_wr_data = wdat;
        @(negedge clk);
        op_valid = 1'b0; sw_wr_en = 1'b0;
        chk({req, " status user"}, 64'(stat_u), 64'(exp_stat));
        chk({req, " status sys"}, 64'(stat_s), 64'(exp_stat));
        chk({req, " pulse user"}, 64'(pulse_u), 64'(tu));
        chk({req, " pulse sys"}, 64'(pulse_s), 64'(ts));
        chk({req, " summary user"}, 64'(sum_u), tu ? 64'(su) : 64'(0));
        chk({req, " summary sys"}, 64'(sum_s), ts ? 64'(ss) : 64'(0));
        chk({req, " regmask user"}, 64'(mask_u), tu ? (64'(1) << dst) : 64'(0));
        chk({req, " regmask sys"}, 64'(mask_s), ts ? (64'(1) << dst) : 64'(0));
        @(negedge clk);
        chk("R4 pulse ends user", 64'(pulse_u), 64'(0));
        chk("R4 pulse ends sys", 64'(pulse_s), 64'(0));
    endtask

    task automatic t_reset();
        chk("R1 status", 64'(stat_u), 64'(0));
        chk("R1 pulse", 64'(pulse_u | pulse_s), 64'(0));
        chk("R1 summary", 64'(sum_u | sum_s), 64'(0));
        chk("R1 regmask", 64'(mask_u | mask_s), 64'(0));
    endtask

    task automatic t_plain();
        run_op("R2 R3 plain trap", 6'b010101, 6'b000100, 6'b000000, 5'd5, 1'b0, 1'b0, 6'd0);
        run_op("R2 R3 plain all ignored", 6'b100010, 6'b100010, 6'b111111, 5'd3, 1'b0, 1'b0, 6'd0);
    endtask

    task automatic t_no_valid();
        @(negedge clk);
        op_flags = 6'b111111; ignore_mask = '0; swc_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 idle status", 64'(stat_u), 64'(exp_stat));
        chk("R4 idle pulse", 64'(pulse_u | pulse_s), 64'(0));
        op_flags = '0;
    endtask

    task automatic t_sticky();
        run_op("R10 no flags", 6'b000000, 6'b000000, 6'b000000, 5'd1, 1'b0, 1'b0, 6'd0);
    endtask

    task automatic t_write();
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = 6'b000000;
        @(negedge clk);
        sw_wr_en = 1'b0;
        exp_stat = '0;
        chk("R9 write clears user", 64'(stat_u), 64'(0));
        chk("R9 write clears sys", 64'(stat_s), 64'(0));
    endtask

    task automatic t_swc();
        run_op("R5 R6 swc enabled", 6'b011001, 6'b000001, 6'b001000, 5'd9, 1'b1, 1'b0, 6'd0);
        run_op("R7 swc disabled flag", 6'b000010, 6'b000000, 6'b000001, 5'd12, 1'b1, 1'b0, 6'd0);
        run_op("R5 swc ignored not sticky", 6'b100000, 6'b100000, 6'b111111, 5'd2, 1'b1, 1'b0, 6'd0);
    endtask

    task automatic t_collision();
        run_op("R9 collision", 6'b100000, 6'b000000, 6'b000000, 5'd7, 1'b0, 1'b1, 6'b000001);
    endtask

    task automatic t_regmask_edges();
        run_op("R8 dest 0", 6'b000001, 6'b000000, 6'b000000, 5'd0, 1'b0, 1'b0, 6'd0);
        run_op("R8 dest 31", 6'b000100, 6'b000000, 6'b000100, 5'd31, 1'b1, 1'b0, 6'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_no_valid();
        t_sticky();
        t_write();
        t_swc();
        t_collision();
        t_regmask_edges();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule